// File: doc/BRIEF.md
# Link-Rate Transceiver Reconfiguration Controller

This controller lets a serial link move between four line rates without running a transceiver calibration at every move. Once reset is released it works through every rate, one after another. For each rate it programs the divider settings of the transmit PLL and of the receive clock-recovery loop. It then starts one calibration pass and waits for it to end. It then reads back fourteen calibration registers and keeps them in an internal table, one row per rate.

When the sweep is over the block raises `ready`, and link training may begin. From then on, each rate request is served by a restore pass and never by a new calibration. The restore pass writes the divider settings for the requested rate, then writes the fourteen saved calibration values for that rate. The transceiver is reached through a small memory-mapped configuration port with a 10-bit address, separate read and write strobes, and a waitrequest stall.

Top module: `lrate_reconfig_ctrl`

## Requirements
- R1: While `rst_n` is low, `ready` and `cal_start` are low. After reset is released, the first configuration access is a write of 0x40 to address 0x12B.
- R2: Rate indices are swept in the order 0, 1, 2, 3. Each rate `r` gets exactly 18 accesses:
  - four writes, to 0x12B, 0x12C, 0x13A and 0x13B in that order (divider slot k = 0..3), with data 0x40 + 16·r + k;
  - then fourteen reads, in the order 0x10A, 0x10B, 0x142, 0x123, 0x124, 0x125, 0x126, 0x132, 0x133, 0x134, 0x135, 0x136, 0x137, 0x139.
- R3: The rate index encodes 0 = 1.62, 1 = 2.7, 2 = 5.4 and 3 = 8.1 Gb/s. `cur_rate` shows the rate last programmed, so it reads 3 when the sweep ends.
- R4: `ready` rises in the cycle after the last sweep read is acknowledged. While `ready` is high, no configuration access is made.
- R5: A restore pass for rate `r` makes 18 writes and no reads:
  - the four divider writes of R2 for rate `r`;
  - then one write to each of the fourteen calibration addresses, in the R2 order, carrying the value read at that address after the calibration of rate `r`.
  - `cal_start` never pulses once `ready` has first been high.
- R6: A request with `rate_req_valid` high while `ready` is high is accepted, and `ready` is low from the next cycle on. `ready` returns high in the cycle after the last restore write is acknowledged, and `cur_rate` then equals the requested index.
- R7: A request that arrives during the sweep or during a restore is held and served once that pass ends. With `LATEST_WINS` = 1, a later held request replaces an earlier one.
- R8: While `cfg_waitreq` is high, an access in progress keeps its strobe, address and write data unchanged. The access completes on the first clock edge at which `cfg_waitreq` is low.
- R9: `cal_start` is a single-cycle pulse, given once per swept rate after its divider writes. The calibration reads start only after `cal_busy` has been seen high and has then fallen.
- R10: `cfg_read` and `cfg_write` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_req_valid | input | 1 | One-cycle rate request strobe |
| rate_req_idx | input | $clog2(N_RATES) | Requested rate index |
| ready | output | 1 | Transceiver set up for `cur_rate`; link training may proceed |
| cur_rate | output | $clog2(N_RATES) | Rate index last programmed |
| cfg_addr | output | ADDR_W | Configuration register address |
| cfg_read | output | 1 | Read strobe |
| cfg_write | output | 1 | Write strobe |
| cfg_wdata | output | DATA_W | Write data |
| cfg_rdata | input | DATA_W | Read data, valid while `cfg_read` is high and `cfg_waitreq` is low |
| cfg_waitreq | input | 1 | Stall for the current access |
| cal_start | output | 1 | Calibration start pulse |
| cal_busy | input | 1 | Calibration in progress |

## Verification
The bench builds the block with its default parameters: four rates, a 10-bit address, 8-bit data and the variant in which the newest held request wins. With four rates, the table row select, the last-rate exit from the sweep and the wrap of `cur_rate` are all exercised. The 8-bit data width lets each saved calibration value be traced from the read that captured it to the restore write that replays it. The newest-wins variant is the one under which a burst of requests during a restore collapses into a single pass.

// File: rtl/lrate_pkg.sv
package lrate_pkg;

   // Divider slots and saved calibration registers per rate
   localparam int N_DIV  = 4;
   localparam int N_CAL  = 14;
   localparam int N_STEP = N_DIV + N_CAL;

   typedef enum logic [2:0] {
      ST_DIVW,     // sweep: program dividers
      ST_CALGO,    // sweep: start pulse
      ST_CALHI,    // sweep: wait for busy to rise
      ST_CALLO,    // sweep: wait for busy to fall
      ST_CALRD,    // sweep: capture calibration registers
      ST_READY,    // idle, link usable
      ST_RESTORE   // replay dividers and saved values
   } seq_st_e;

   // Divider register addresses: TX PLL M, TX PLL L, RX CDR L/PFD/PD, RX CDR M
   function automatic logic [9:0] div_addr(input int k);
      case (k)
         0:       return 10'h12B;
         1:       return 10'h12C;
         2:       return 10'h13A;
         default: return 10'h13B;
      endcase
   endfunction

   // Calibration result registers: seven on the TX PLL, then seven on the RX CDR
   function automatic logic [9:0] cal_addr(input int k);
      case (k)
         0:       return 10'h10A;
         1:       return 10'h10B;
         2:       return 10'h142;
         3:       return 10'h123;
         4:       return 10'h124;
         5:       return 10'h125;
         6:       return 10'h126;
         7:       return 10'h132;
         8:       return 10'h133;
         9:       return 10'h134;
         10:      return 10'h135;
         11:      return 10'h136;
         12:      return 10'h137;
         default: return 10'h139;
      endcase
   endfunction

   // Divider setting for rate r, slot k (constant table in closed form)
   function automatic logic [7:0] div_value(input int r, input int k);
      return 8'(8'h40 + 16 * r + k);
   endfunction

endpackage

// File: rtl/lrate_cal_store.sv
module lrate_cal_store
   import lrate_pkg::*;
#(
   parameter int N_RATES = 4,
   parameter int DATA_W  = 8,
   localparam int RATE_W = $clog2(N_RATES),
   localparam int CIDX_W = $clog2(N_CAL)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [RATE_W-1:0] wr_rate,
   input  logic [CIDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [RATE_W-1:0] rd_rate,
   input  logic [CIDX_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] tbl [N_RATES][N_CAL];

   always_ff @(posedge clk) begin
      if (we && (int'(wr_idx) < N_CAL))
         tbl[wr_rate][wr_idx] <= wdata;
   end

   always_comb begin
      rdata = '0;
      if (int'(rd_idx) < N_CAL)
         rdata = tbl[rd_rate][rd_idx];
   end

endmodule

// File: rtl/lrate_req_hold.sv
module lrate_req_hold #(
   parameter int N_RATES     = 4,
   parameter bit LATEST_WINS = 1'b1,
   localparam int RATE_W     = $clog2(N_RATES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [RATE_W-1:0] req_rate,
   input  logic              take,
   output logic              any,
   output logic [RATE_W-1:0] sel_rate
);

   logic              pend_v;
   logic [RATE_W-1:0] pend_r;

   assign any = req_valid | pend_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_v <= 1'b0;
      else if (take)     pend_v <= 1'b0;
      else if (req_valid) pend_v <= 1'b1;
   end

   generate
      if (LATEST_WINS) begin : g_latest
         assign sel_rate = req_valid ? req_rate : pend_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  pend_r <= '0;
            else if (req_valid && !take) pend_r <= req_rate;
         end
      end else begin : g_first
         assign sel_rate = pend_v ? pend_r : req_rate;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             pend_r <= '0;
            else if (req_valid && !take && !pend_v) pend_r <= req_rate;
         end
      end
   endgenerate

endmodule

// File: rtl/lrate_seq.sv
module lrate_seq
   import lrate_pkg::*;
#(
   parameter int N_RATES = 4,
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 8,
   localparam int RATE_W = $clog2(N_RATES),
   localparam int SIDX_W = $clog2(N_STEP),
   localparam int CIDX_W = $clog2(N_CAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   // configuration port
   output logic [ADDR_W-1:0] cfg_addr,
   output logic              cfg_read,
   output logic              cfg_write,
   output logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_waitreq,
   // calibration handshake
   output logic              cal_start,
   input  logic              cal_busy,
   // request holder
   input  logic              req_any,
   input  logic [RATE_W-1:0] req_rate,
   output logic              req_take,
   // calibration table
   output logic              st_we,
   output logic [RATE_W-1:0] st_rate,
   output logic [CIDX_W-1:0] st_idx,
   input  logic [DATA_W-1:0] st_rdata,
   // status
   output logic              ready,
   output logic [RATE_W-1:0] cur_rate
);

   seq_st_e           st;
   logic [SIDX_W-1:0] idx;
   logic [RATE_W-1:0] rate_q;
   logic [SIDX_W-1:0] cal_sel;
   logic              acked;

   assign acked = ~cfg_waitreq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_DIVW;
         idx    <= '0;
         rate_q <= '0;
      end else begin
         unique case (st)
            ST_DIVW: if (acked) begin
               if (idx == SIDX_W'(N_DIV - 1)) begin
                  idx <= '0;
                  st  <= ST_CALGO;
               end else idx <= idx + 1'b1;
            end
            ST_CALGO: st <= ST_CALHI;
            ST_CALHI: if (cal_busy)  st <= ST_CALLO;
            ST_CALLO: if (!cal_busy) st <= ST_CALRD;
            ST_CALRD: if (acked) begin
               if (idx == SIDX_W'(N_CAL - 1)) begin
                  idx <= '0;
                  if (rate_q == RATE_W'(N_RATES - 1)) st <= ST_READY;
                  else begin
                     rate_q <= rate_q + 1'b1;
                     st     <= ST_DIVW;
                  end
               end else idx <= idx + 1'b1;
            end
            ST_READY: if (req_any) begin
               st     <= ST_RESTORE;
               rate_q <= req_rate;
               idx    <= '0;
            end
            ST_RESTORE: if (acked) begin
               if (idx == SIDX_W'(N_STEP - 1)) begin
                  idx <= '0;
                  st  <= ST_READY;
               end else idx <= idx + 1'b1;
            end
            default: st <= ST_READY;
         endcase
      end
   end

   // Table index: direct during capture, offset past the dividers during replay
   assign cal_sel = (st == ST_CALRD) ? idx : idx - SIDX_W'(N_DIV);
   assign st_idx  = CIDX_W'(cal_sel);
   assign st_rate = rate_q;
   assign st_we   = (st == ST_CALRD) && acked;

   always_comb begin
      cfg_write = (st == ST_DIVW) || (st == ST_RESTORE);
      cfg_read  = (st == ST_CALRD);
      cfg_addr  = '0;
      cfg_wdata = '0;
      if (st == ST_CALRD)
         cfg_addr = ADDR_W'(cal_addr(int'(idx)));
      else if (cfg_write) begin
         if (int'(idx) < N_DIV) begin
            cfg_addr  = ADDR_W'(div_addr(int'(idx)));
            cfg_wdata = DATA_W'(div_value(int'(rate_q), int'(idx)));
         end else begin
            cfg_addr  = ADDR_W'(cal_addr(int'(idx) - N_DIV));
            cfg_wdata = st_rdata;
         end
      end
   end

   assign cal_start = (st == ST_CALGO);
   assign ready     = (st == ST_READY);
   assign req_take  = (st == ST_READY);
   assign cur_rate  = rate_q;

endmodule

// File: rtl/lrate_reconfig_ctrl.sv
module lrate_reconfig_ctrl
   import lrate_pkg::*;
#(
   parameter int N_RATES     = 4,
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter bit LATEST_WINS = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rate_req_valid,
   input  logic [$clog2(N_RATES)-1:0] rate_req_idx,
   output logic                       ready,
   output logic [$clog2(N_RATES)-1:0] cur_rate,
   output logic [ADDR_W-1:0]          cfg_addr,
   output logic                       cfg_read,
   output logic                       cfg_write,
   output logic [DATA_W-1:0]          cfg_wdata,
   input  logic [DATA_W-1:0]          cfg_rdata,
   input  logic                       cfg_waitreq,
   output logic                       cal_start,
   input  logic                       cal_busy
);

   localparam int RATE_W = $clog2(N_RATES);
   localparam int CIDX_W = $clog2(N_CAL);

   generate
      if (N_RATES < 2 || N_RATES > 4) begin : g_bad_rates
         $error("N_RATES must lie in 2..4");
      end
      if (ADDR_W < 10) begin : g_bad_addr
         $error("ADDR_W must be at least 10");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic              req_any, req_take;
   logic [RATE_W-1:0] req_rate;
   logic              st_we;
   logic [RATE_W-1:0] st_rate;
   logic [CIDX_W-1:0] st_idx;
   logic [DATA_W-1:0] st_rdata;

   lrate_req_hold #(
      .N_RATES     (N_RATES),
      .LATEST_WINS (LATEST_WINS)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (rate_req_valid),
      .req_rate  (rate_req_idx),
      .take      (req_take),
      .any       (req_any),
      .sel_rate  (req_rate)
   );

   lrate_cal_store #(
      .N_RATES (N_RATES),
      .DATA_W  (DATA_W)
   ) u_store (
      .clk     (clk),
      .we      (st_we),
      .wr_rate (st_rate),
      .wr_idx  (st_idx),
      .wdata   (cfg_rdata),
      .rd_rate (st_rate),
      .rd_idx  (st_idx),
      .rdata   (st_rdata)
   );

   lrate_seq #(
      .N_RATES (N_RATES),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_addr    (cfg_addr),
      .cfg_read    (cfg_read),
      .cfg_write   (cfg_write),
      .cfg_wdata   (cfg_wdata),
      .cfg_waitreq (cfg_waitreq),
      .cal_start   (cal_start),
      .cal_busy    (cal_busy),
      .req_any     (req_any),
      .req_rate    (req_rate),
      .req_take    (req_take),
      .st_we       (st_we),
      .st_rate     (st_rate),
      .st_idx      (st_idx),
      .st_rdata    (st_rdata),
      .ready       (ready),
      .cur_rate    (cur_rate)
   );

endmodule

// File: rtl/lrate_reconfig_chk.sv
module lrate_reconfig_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rate_req_valid,
   input logic              ready,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic              cfg_read,
   input logic              cfg_write,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              cfg_waitreq,
   input logic              cal_start
);

   logic seen_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     seen_ready <= 1'b0;
      else if (ready) seen_ready <= 1'b1;
   end

   // R10
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_read && cfg_write));

   // R8
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_write && cfg_waitreq) |=> (cfg_write && $stable(cfg_addr) && $stable(cfg_wdata)));

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_read && cfg_waitreq) |=> (cfg_read && $stable(cfg_addr)));

   // R9
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> !cal_start);

   // R5
   no_recal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_ready |-> !cal_start);

   // R6
   accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && rate_req_valid) |=> !ready);

   // R4
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !(cfg_read || cfg_write));

endmodule

bind lrate_reconfig_ctrl lrate_reconfig_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rate_req_valid (rate_req_valid),
   .ready          (ready),
   .cfg_addr       (cfg_addr),
   .cfg_read       (cfg_read),
   .cfg_write      (cfg_write),
   .cfg_wdata      (cfg_wdata),
   .cfg_waitreq    (cfg_waitreq),
   .cal_start      (cal_start)
);

// File: tb/lrate_reconfig_ctrl_bench.sv
`timescale 1ns/1ps
module lrate_reconfig_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rate_req_valid = 1'b0;
   logic [1:0] rate_req_idx = 2'd0;
   logic       ready;
   logic [1:0] cur_rate;
   logic [9:0] cfg_addr;
   logic       cfg_read, cfg_write;
   logic [7:0] cfg_wdata;
   logic [7:0] cfg_rdata;
   logic       cfg_waitreq = 1'b0;
   logic       cal_start;
   logic       cal_busy = 1'b0;

   always #2 clk = ~clk;

   lrate_reconfig_ctrl u_lrate_reconfig_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .rate_req_valid (rate_req_valid),
      .rate_req_idx   (rate_req_idx),
      .ready          (ready),
      .cur_rate       (cur_rate),
      .cfg_addr       (cfg_addr),
      .cfg_read       (cfg_read),
      .cfg_write      (cfg_write),
      .cfg_wdata      (cfg_wdata),
      .cfg_rdata      (cfg_rdata),
      .cfg_waitreq    (cfg_waitreq),
      .cal_start      (cal_start),
      .cal_busy       (cal_busy)
   );

   // Transceiver register file model
   logic [7:0] xmem [1024];
   assign cfg_rdata = xmem[cfg_addr];

   int checks = 0, errors = 0, cyc = 0;
   bit sweeping = 1'b1, swept = 1'b0, stall_en = 1'b1;
   int acc_n = 0, sweep_rate = 0, cal_pass = 0, cal_phase = 0, cal_wait = 0;
   int rq [64];
   int rq_head = 0, rq_tail = 0, streams_done = 0;

   // Access k of an 18-step pass: dividers first, then calibration registers (R2)
   function automatic logic [9:0] f_addr(input int k);
      case (k)
         0: return 10'h12B;   1: return 10'h12C;   2: return 10'h13A;
         3: return 10'h13B;   4: return 10'h10A;   5: return 10'h10B;
         6: return 10'h142;   7: return 10'h123;   8: return 10'h124;
         9: return 10'h125;  10: return 10'h126;  11: return 10'h132;
         12: return 10'h133; 13: return 10'h134;  14: return 10'h135;
         15: return 10'h136; 16: return 10'h137;  default: return 10'h139;
      endcase
   endfunction

   function automatic logic [7:0] f_div(input int r, input int k);
      return 8'(8'h40 + 16 * r + k);
   endfunction

   // Value the calibration model leaves in register j after calibrating rate r
   function automatic logic [7:0] f_cal(input int r, input int j);
      return 8'(32'h80 ^ (r * 37 + j * 11));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Transceiver, calibration and access monitor, all at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
      if (rst_n) begin
         cfg_waitreq = stall_en ? (($urandom % 4) == 0) : 1'b0;
         // R6: ready low through a restore pass
         if (!sweeping && acc_n != 0) chk(!ready, "R6 ready during restore", int'(ready), 0);
         // calibration model
         if (cal_start) begin
            chk(!swept, "R5 no calibration after ready", int'(swept), 0);
            cal_phase = 1;
            cal_wait  = 1 + int'($urandom % 3);
         end else if (cal_phase == 1) begin
            cal_wait--;
            if (cal_wait == 0) begin
               cal_busy  = 1'b1;
               cal_phase = 2;
               cal_wait  = 2 + int'($urandom % 5);
            end
         end else if (cal_phase == 2) begin
            cal_wait--;
            if (cal_wait == 0) begin
               cal_busy  = 1'b0;
               cal_phase = 0;
               for (int j = 0; j < 14; j++) xmem[f_addr(j + 4)] = f_cal(cal_pass, j);
               cal_pass++;
            end
         end
         // access monitor
         if ((cfg_write || cfg_read) && !cfg_waitreq) begin
            if (sweeping) begin
               chk(cfg_addr == f_addr(acc_n), (acc_n == 0 && sweep_rate == 0) ? "R1 first address" : "R2 sweep address",
                   int'(cfg_addr), int'(f_addr(acc_n)));
               chk(cfg_write == (acc_n < 4), "R2 sweep direction", int'(cfg_write), int'(acc_n < 4));
               if (acc_n < 4)
                  chk(cfg_wdata == f_div(sweep_rate, acc_n), "R2 divider value", int'(cfg_wdata),
                      int'(f_div(sweep_rate, acc_n)));
               else if (acc_n == 4)
                  chk(cal_pass == sweep_rate + 1, "R9 reads after calibration", cal_pass, sweep_rate + 1);
               if (cfg_write) xmem[cfg_addr] = cfg_wdata;
               acc_n++;
               if (acc_n == 18) begin
                  acc_n = 0;
                  sweep_rate++;
                  if (sweep_rate == 4) sweeping = 1'b0;
               end
            end else if (rq_head == rq_tail) begin
               chk(1'b0, "R4 unexpected access", int'(cfg_addr), 0);
            end else begin
               int r;
               logic [7:0] ev;
               r  = rq[rq_head % 64];
               ev = (acc_n < 4) ? f_div(r, acc_n) : f_cal(r, acc_n - 4);
               chk(cfg_write, "R5 restore is writes only", int'(cfg_write), 1);
               chk(cfg_addr == f_addr(acc_n), "R5 restore address", int'(cfg_addr), int'(f_addr(acc_n)));
               chk(cfg_wdata == ev, "R5 restore value", int'(cfg_wdata), int'(ev));
               if (cfg_write) xmem[cfg_addr] = cfg_wdata;
               acc_n++;
               if (acc_n == 18) begin
                  acc_n = 0;
                  rq_head++;
                  streams_done++;
               end
            end
         end
         if (ready) swept = 1'b1;
      end
   end

   task automatic scramble();
      for (int k = 0; k < 18; k++) xmem[f_addr(k)] = 8'($urandom);
   endtask

   task automatic send(input int r, input bit push, input bit check_drop);
      rate_req_valid = 1'b1;
      rate_req_idx   = 2'(r);
      if (push) begin
         rq[rq_tail % 64] = r;
         rq_tail++;
      end
      @(negedge clk);
      rate_req_valid = 1'b0;
      if (check_drop) chk(!ready, "R6 ready drops after accept", int'(ready), 0);
   endtask

   task automatic finish_and_verify(input int n, input int r);
      while (streams_done < n) @(negedge clk);
      @(negedge clk);
      chk(ready, "R6 ready after restore", int'(ready), 1);
      chk(cur_rate == 2'(r), "R6 cur_rate", int'(cur_rate), r);
      for (int k = 0; k < 18; k++) begin
         logic [7:0] ev;
         ev = (k < 4) ? f_div(r, k) : f_cal(r, k - 4);
         chk(xmem[f_addr(k)] == ev, "R5 restored register", int'(xmem[f_addr(k)]), int'(ev));
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int a = 0; a < 1024; a++) xmem[a] = 8'h00;
      repeat (4) @(negedge clk);
      chk(!ready, "R1 ready in reset", int'(ready), 0);
      chk(!cal_start, "R1 cal_start in reset", int'(cal_start), 0);
      rst_n = 1'b1;

      // R7: requests during the sweep; the later one replaces the earlier
      while (sweep_rate < 1) @(negedge clk);
      send(0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      send(1, 1'b1, 1'b0);

      // R3, R4: sweep ends on rate 3 with ready high
      while (!ready) @(negedge clk);
      chk(cur_rate == 2'd3, "R3 cur_rate after sweep", int'(cur_rate), 3);
      chk(sweep_rate == 4, "R4 sweep complete at ready", sweep_rate, 4);
      chk(cal_pass == 4, "R9 one calibration per rate", cal_pass, 4);
      @(negedge clk);
      chk(!ready, "R7 held request served", int'(ready), 0);
      finish_and_verify(1, 1);

      // Same rate again, then every rate directed, no stalls
      stall_en = 1'b0;
      scramble();
      send(1, 1'b1, 1'b1);
      finish_and_verify(2, 1);
      stall_en = 1'b1;
      for (int r = 3; r >= 0; r--) begin
         scramble();
         send(r, 1'b1, 1'b1);
         finish_and_verify(streams_done + 1, r);
      end

      // R7: burst of requests during a restore collapses to the newest
      scramble();
      send(2, 1'b1, 1'b1);
      while (acc_n < 5) @(negedge clk);
      send(0, 1'b0, 1'b0);
      @(negedge clk);
      send(3, 1'b1, 1'b0);
      finish_and_verify(streams_done + 2, 3);

      // Random requests with random stalls
      for (int i = 0; i < 12; i++) begin
         int r;
         r = int'($urandom % 4);
         stall_en = ($urandom % 2) == 0;
         scramble();
         repeat (int'($urandom % 4)) @(negedge clk);
         send(r, 1'b1, 1'b1);
         finish_and_verify(streams_done + 1, r);
      end

      chk(cal_pass == 4, "R5 no calibration during restores", cal_pass, 4);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule